// File: doc/BRIEF.md
# Transmit Packet Framer

This block turns a packet handed over byte by byte into a serial bit stream with a fixed frame layout. A frame opens with a run of preamble bytes. A 16-bit address follows, which is either the node's own or the global one. Then come a length byte, the payload bytes the length announces, and, when enabled, a CRC-8 byte. Bits leave most significant first, one per strobe, with a configurable number of clock cycles per bit.

There are two ways to feed it. In streaming mode the framer first sends the preamble and the address on its own. It then asks the host for the length byte and the payload one byte at a time, just in time to keep the serialiser busy. In buffered mode a start command raises a one-cycle interrupt. The framer then asks for the whole packet, stores it in an internal buffer, and sends the preamble only once the last byte has arrived. In both modes the block drops back to standby when the final bit has left, and ignores start commands until then.

Top module: `pkt_tx_framer`

## Requirements
- R1: Out of reset the block is in standby: busy_o, irq_o, bit_stb_o and byte_req_o are all low.
- R2: A frame with the address enabled is sent as 4 bytes of 0xAA, the address high byte, the address low byte, the length byte, and then the payload bytes in the order they were supplied. Every byte goes out most significant bit first, one bit per bit_stb_o pulse.
- R3: With cfg_global_id_i high at the start command the frame carries global_id_i; with it low it carries node_id_i.
- R4: With cfg_use_id_i low at the start command both address bytes are left out, and the length byte directly follows the preamble.
- R5: A byte is accepted in a cycle where load_valid_i and byte_req_o are both high. The first accepted byte is the length N, and exactly N further bytes are requested after it. byte_req_o then stays low for the rest of the frame, even when the host answers requests with delays.
- R6: In streaming mode byte_req_o does not rise until every preamble and address byte has been handed to the serialiser. With the address enabled, at least 40 bits have appeared by then.
- R7: In buffered mode the start command produces exactly one irq_o pulse of one cycle, while byte_req_o is high. No bit is sent until all N+1 packet bytes have been accepted.
- R8: With cfg_crc_en_i high a final byte is appended: CRC-8 with polynomial 0x07, initial value 0x00, no reflection and no final inversion, over the length byte and the payload. With it low, no byte follows the payload.
- R9: A length of zero sends the preamble, the address, the length byte and, if enabled, the CRC byte, and nothing else, in both modes.
- R10: After the last bit the block returns to standby with busy_o low. bit_stb_o and byte_req_o never pulse while busy_o is low.
- R11: A start command given while busy_o is high is ignored. The frame in progress keeps its address selection, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transmit command, sampled only in standby |
| cfg_use_id_i | input | 1 | Send the 16-bit address after the preamble |
| cfg_global_id_i | input | 1 | 1 selects the global address, 0 the node address |
| cfg_buffered_i | input | 1 | 1 loads the whole packet before sending |
| cfg_crc_en_i | input | 1 | Append the CRC-8 byte |
| node_id_i | input | 16 | Node's own address |
| global_id_i | input | 16 | Global address |
| load_valid_i | input | 1 | Host offers a byte |
| load_data_i | input | 8 | Offered byte |
| byte_req_o | output | 1 | Block wants a byte |
| bit_o | output | 1 | Serial data, valid while bit_stb_o is high |
| bit_stb_o | output | 1 | One pulse per transmitted bit |
| busy_o | output | 1 | Frame in progress |
| irq_o | output | 1 | One-cycle pulse: buffered packet may be loaded |

## Verification
The assertions assume start_i and load_valid_i are known after reset. They also assume the host never announces a length above the buffer's capacity in buffered mode, since a longer packet would run past the stored bytes. The bench's host model offers a byte only in a cycle where byte_req_o is high, counts any request it sees once the packet has been fully handed over, and uses lengths of 0 to 12, which stay far below the 255-byte capacity. A slow-host variant answers only every other request cycle, so the serialiser has to wait for payload without the request rule being broken.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_LOAD,
      ST_PRE,
      ST_IDH,
      ST_IDL,
      ST_LEN,
      ST_PAY,
      ST_CRC,
      ST_DRAIN
   } tx_state_e;

   // One byte of a left-shifting CRC-8 (no reflection)
   function automatic logic [7:0] crc8_step(input logic [7:0] crc,
                                            input logic [7:0] data,
                                            input logic [7:0] poly);
      logic [7:0] c;
      c = crc ^ data;
      for (int i = 0; i < 8; i++) begin
         c = c[7] ? ((c << 1) ^ poly) : (c << 1);
      end
      return c;
   endfunction

endpackage

// File: rtl/pkt_tx_shifter.sv
module pkt_tx_shifter #(
   parameter int BIT_DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_i,
   input  logic [7:0] byte_i,
   output logic       ready_o,
   output logic       bit_o,
   output logic       stb_o
);
   localparam int DW = (BIT_DIV < 2) ? 1 : $clog2(BIT_DIV);

   logic [7:0] data_q;
   logic [3:0] left_q;
   logic       bit_q;
   logic       stb_q;
   logic       tick;

   assign ready_o = (left_q == 4'd0);

   generate
      if (BIT_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (load_i || (left_q == 4'd0)) begin
               div_q <= '0;
            end else if (div_q == DW'(BIT_DIV - 1)) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
         assign tick = (div_q == DW'(BIT_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         left_q <= '0;
         bit_q  <= 1'b0;
         stb_q  <= 1'b0;
      end else if (load_i) begin
         data_q <= byte_i;
         left_q <= 4'd8;
         stb_q  <= 1'b0;
      end else if ((left_q != 4'd0) && tick) begin
         bit_q  <= data_q[7];
         data_q <= {data_q[6:0], 1'b0};
         left_q <= left_q - 4'd1;
         stb_q  <= 1'b1;
      end else begin
         stb_q  <= 1'b0;
      end
   end

   assign bit_o = bit_q;
   assign stb_o = stb_q;
endmodule

// File: rtl/pkt_tx_buffer.sv
module pkt_tx_buffer #(
   parameter int DEPTH = 256,
   parameter int AW    = 8
) (
   input  logic          clk,
   input  logic          wr_en_i,
   input  logic [AW-1:0] wr_addr_i,
   input  logic [7:0]    wr_data_i,
   input  logic [AW-1:0] rd_addr_i,
   output logic [7:0]    rd_data_o
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
   end

   assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/pkt_tx_crc.sv
module pkt_tx_crc
   import pkt_tx_pkg::*;
#(
   parameter logic [7:0] POLY = 8'h07
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic       upd_i,
   input  logic [7:0] byte_i,
   output logic [7:0] crc_o
);
   logic [7:0] crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= '0;
      else if (clr_i) crc_q <= '0;
      else if (upd_i) crc_q <= crc8_step(crc_q, byte_i, POLY);
   end

   assign crc_o = crc_q;
endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer
   import pkt_tx_pkg::*;
#(
   parameter int         PRE_BYTES   = 4,
   parameter logic [7:0] PRE_PATTERN = 8'hAA,
   parameter int         BIT_DIV     = 4,
   parameter int         MAX_LEN     = 255,
   parameter bit         HAS_BUFFER  = 1'b1,
   parameter bit         HAS_CRC     = 1'b1,
   parameter logic [7:0] CRC_POLY    = 8'h07
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        cfg_use_id_i,
   input  logic        cfg_global_id_i,
   input  logic        cfg_buffered_i,
   input  logic        cfg_crc_en_i,
   input  logic [15:0] node_id_i,
   input  logic [15:0] global_id_i,
   input  logic        load_valid_i,
   input  logic [7:0]  load_data_i,
   output logic        byte_req_o,
   output logic        bit_o,
   output logic        bit_stb_o,
   output logic        busy_o,
   output logic        irq_o
);
   localparam int DEPTH = MAX_LEN + 1;
   localparam int AW    = (DEPTH < 3) ? 1 : $clog2(DEPTH);

   generate
      if (PRE_BYTES < 1 || PRE_BYTES > 255) begin : g_bad_pre
         $error("PRE_BYTES must lie in 1..255");
      end
      if (MAX_LEN < 1 || MAX_LEN > 255) begin : g_bad_len
         $error("MAX_LEN must lie in 1..255");
      end
      if (BIT_DIV < 1) begin : g_bad_div
         $error("BIT_DIV must be at least 1");
      end
   endgenerate

   tx_state_e     state_q;
   logic [7:0]    cnt_q;
   logic [7:0]    len_q;
   logic [AW-1:0] wr_ptr_q;
   logic          use_id_q, buf_q, crc_on_q, irq_q;
   logic [15:0]   id_q;
   logic [7:0]    stage_q;
   logic          stage_vld_q;

   logic          sh_ready, sh_push;
   logic [7:0]    sh_byte;
   logic [7:0]    rd_data, crc_val, src_byte;
   logic [AW-1:0] rd_addr;
   logic          src_ok, take, in_body, crc_upd, crc_clr;
   tx_state_e     after_body;

   assign in_body    = (state_q == ST_LEN) || (state_q == ST_PAY);
   assign byte_req_o = (state_q == ST_LOAD) || (!buf_q && in_body && !stage_vld_q);
   assign take       = load_valid_i && byte_req_o;
   assign src_byte   = buf_q ? rd_data : stage_q;
   assign src_ok     = buf_q || stage_vld_q;
   assign rd_addr    = (state_q == ST_LEN) ? '0 : AW'(cnt_q + 8'd1);
   assign after_body = crc_on_q ? ST_CRC : ST_DRAIN;
   assign crc_clr    = (state_q == ST_IDLE) && start_i;
   assign crc_upd    = sh_push && in_body;

   always_comb begin
      sh_push = 1'b0;
      sh_byte = PRE_PATTERN;
      unique case (state_q)
         ST_PRE: sh_push = sh_ready;
         ST_IDH: begin sh_push = sh_ready; sh_byte = id_q[15:8]; end
         ST_IDL: begin sh_push = sh_ready; sh_byte = id_q[7:0];  end
         ST_LEN, ST_PAY: begin sh_push = sh_ready && src_ok; sh_byte = src_byte; end
         ST_CRC: begin sh_push = sh_ready; sh_byte = crc_val; end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cnt_q       <= '0;
         len_q       <= '0;
         wr_ptr_q    <= '0;
         use_id_q    <= 1'b0;
         buf_q       <= 1'b0;
         crc_on_q    <= 1'b0;
         irq_q       <= 1'b0;
         id_q        <= '0;
         stage_q     <= '0;
         stage_vld_q <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (take && !buf_q && state_q != ST_LOAD) begin
            stage_q     <= load_data_i;
            stage_vld_q <= 1'b1;
         end else if (sh_push && in_body) begin
            stage_vld_q <= 1'b0;
         end
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               use_id_q    <= cfg_use_id_i;
               buf_q       <= cfg_buffered_i && HAS_BUFFER;
               crc_on_q    <= cfg_crc_en_i && HAS_CRC;
               id_q        <= cfg_global_id_i ? global_id_i : node_id_i;
               cnt_q       <= '0;
               wr_ptr_q    <= '0;
               stage_vld_q <= 1'b0;
               if (cfg_buffered_i && HAS_BUFFER) begin
                  state_q <= ST_LOAD;
                  irq_q   <= 1'b1;
               end else begin
                  state_q <= ST_PRE;
               end
            end
            ST_LOAD: if (take) begin
               if (wr_ptr_q == '0) len_q <= load_data_i;
               wr_ptr_q <= wr_ptr_q + 1'b1;
               if (((wr_ptr_q == '0) && (load_data_i == 8'd0)) ||
                   ((wr_ptr_q != '0) && (8'(wr_ptr_q) == len_q)))
                  state_q <= ST_PRE;
            end
            ST_PRE: if (sh_push) begin
               if (cnt_q == 8'(PRE_BYTES - 1)) begin
                  cnt_q   <= '0;
                  state_q <= use_id_q ? ST_IDH : ST_LEN;
               end else begin
                  cnt_q <= cnt_q + 8'd1;
               end
            end
            ST_IDH: if (sh_push) state_q <= ST_IDL;
            ST_IDL: if (sh_push) state_q <= ST_LEN;
            ST_LEN: if (sh_push) begin
               len_q   <= src_byte;
               cnt_q   <= '0;
               state_q <= (src_byte == 8'd0) ? after_body : ST_PAY;
            end
            ST_PAY: if (sh_push) begin
               if (cnt_q == len_q - 8'd1) state_q <= after_body;
               else                       cnt_q   <= cnt_q + 8'd1;
            end
            ST_CRC:   if (sh_push)  state_q <= ST_DRAIN;
            ST_DRAIN: if (sh_ready) state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   generate
      if (HAS_BUFFER) begin : g_buf
         pkt_tx_buffer #(.DEPTH(DEPTH), .AW(AW)) u_buf (
            .clk       (clk),
            .wr_en_i   (take && (state_q == ST_LOAD)),
            .wr_addr_i (wr_ptr_q),
            .wr_data_i (load_data_i),
            .rd_addr_i (rd_addr),
            .rd_data_o (rd_data)
         );
      end else begin : g_nobuf
         assign rd_data = '0;
      end
      if (HAS_CRC) begin : g_crc
         pkt_tx_crc #(.POLY(CRC_POLY)) u_crc (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (crc_clr),
            .upd_i  (crc_upd),
            .byte_i (sh_byte),
            .crc_o  (crc_val)
         );
      end else begin : g_nocrc
         assign crc_val = '0;
      end
   endgenerate

   pkt_tx_shifter #(.BIT_DIV(BIT_DIV)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (sh_push),
      .byte_i  (sh_byte),
      .ready_o (sh_ready),
      .bit_o   (bit_o),
      .stb_o   (bit_stb_o)
   );

   assign busy_o = (state_q != ST_IDLE);
   assign irq_o  = irq_q;
endmodule

// File: rtl/pkt_tx_framer_chk.sv
module pkt_tx_framer_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic busy_o,
   input logic irq_o,
   input logic byte_req_o,
   input logic bit_stb_o
);
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!bit_stb_o && !byte_req_o));

   assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   assert_irq_loading_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (busy_o && byte_req_o));

   assert_irq_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(start_i));

   assert_start_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> busy_o);
endmodule

bind pkt_tx_framer pkt_tx_framer_chk u_chk (.*);

// File: tb/pkt_tx_framer_test.sv
module pkt_tx_framer_test;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        cfg_use_id_i = 1'b0, cfg_global_id_i = 1'b0;
   logic        cfg_buffered_i = 1'b0, cfg_crc_en_i = 1'b0;
   logic [15:0] node_id_i = 16'hC3A5, global_id_i = 16'h5E17;
   logic        load_valid_i = 1'b0;
   logic [7:0]  load_data_i = 8'h00;
   logic        byte_req_o, bit_o, bit_stb_o, busy_o, irq_o;

   pkt_tx_framer uut (.*);

   int checks = 0, errors = 0;
   logic bits [0:8191];
   int bit_cnt = 0;
   logic [7:0] src [0:299];
   logic [7:0] expb [0:299];
   int src_n = 0, exp_n = 0, idx = 0;
   bit drove = 1'b0, host_slow = 1'b0, gap_tog = 1'b0;
   int frame_id = 0, seen_id = 0;
   int extra_req = 0, first_req_bit = -1, load_done_bit = -1, irq_cnt = 0, idle_stb = 0;

   // Host model and bit monitor, away from the active edge
   always @(negedge clk) begin
      if (drove) idx++;
      if (frame_id != seen_id) begin
         seen_id = frame_id; idx = 0; extra_req = 0; first_req_bit = -1;
         load_done_bit = -1; irq_cnt = 0; idle_stb = 0;
      end
      if (bit_stb_o) begin
         bits[bit_cnt] = bit_o;
         bit_cnt++;
         if (!busy_o) idle_stb++;
      end
      if (irq_o) irq_cnt++;
      drove = 1'b0;
      load_valid_i = 1'b0;
      if (byte_req_o) begin
         if (first_req_bit < 0) first_req_bit = bit_cnt;
         if (idx < src_n) begin
            gap_tog = !gap_tog;
            if (!host_slow || gap_tog) begin
               load_valid_i = 1'b1;
               load_data_i  = src[idx];
               drove = 1'b1;
               if (idx == src_n - 1) load_done_bit = bit_cnt;
            end
         end else begin
            extra_req++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] ref_crc(input int n);
      logic [7:0] c = 8'h00;
      for (int k = 0; k < n; k++)
         for (int b = 7; b >= 0; b--) begin
            logic fb;
            fb = c[7] ^ src[k][b];
            c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
         end
      return c;
   endfunction

   task automatic wait_idle(input string req);
      int n = 0;
      while (busy_o && n < 20000) begin @(negedge clk); n++; end
      chk(n < 20000, req, "return to standby cycles", n, 20000);
   endtask

   task automatic run_frame(input bit use_id, input bit glob, input bit bufm,
                            input bit crc, input int len, input bit slow,
                            input int restart_at, input string req);
      int base, wrong, quiet_start;
      logic [15:0] id;
      src[0] = 8'(len);
      for (int i = 1; i <= len; i++) src[i] = 8'(i * 37 + len * 11 + 5);
      src_n = len + 1;
      exp_n = 0;
      for (int i = 0; i < 4; i++) begin expb[exp_n] = 8'hAA; exp_n++; end
      id = glob ? global_id_i : node_id_i;
      if (use_id) begin
         expb[exp_n] = id[15:8]; exp_n++;
         expb[exp_n] = id[7:0];  exp_n++;
      end
      for (int i = 0; i < src_n; i++) begin expb[exp_n] = src[i]; exp_n++; end
      if (crc) begin expb[exp_n] = ref_crc(src_n); exp_n++; end
      frame_id++;
      host_slow = slow;
      @(negedge clk);
      base = bit_cnt;
      cfg_use_id_i = use_id; cfg_global_id_i = glob;
      cfg_buffered_i = bufm; cfg_crc_en_i = crc;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (restart_at > 0) begin
         repeat (restart_at) @(negedge clk);
         cfg_global_id_i = !glob;
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      wait_idle("R10");
      chk(bit_cnt - base == exp_n * 8, req, "bits in frame", bit_cnt - base, exp_n * 8);
      wrong = 0;
      for (int k = 0; k < exp_n && base + 8 * k + 7 < bit_cnt; k++) begin
         logic [7:0] got;
         for (int j = 0; j < 8; j++) got[7 - j] = bits[base + 8 * k + j];
         if (got != expb[k]) begin
            if (wrong == 0)
               $display("FAIL %s byte %0d: actual %0d expected %0d", req, k, got, expb[k]);
            wrong++;
         end
      end
      chk(wrong == 0, req, "mismatching bytes", wrong, 0);
      chk(extra_req == 0 && idx == src_n, "R5", "bytes taken / extra requests",
          idx * 1000 + extra_req, src_n * 1000);
      quiet_start = bit_cnt;
      repeat (24) @(negedge clk);
      chk(!busy_o && bit_cnt == quiet_start && idle_stb == 0, "R10",
          "quiet standby after frame", bit_cnt - quiet_start + idle_stb, 0);
      if (!bufm && use_id)
         chk(first_req_bit - base >= 40, "R6", "bits before first request",
             first_req_bit - base, 40);
      if (bufm) begin
         chk(irq_cnt == 1, "R7", "irq pulses", irq_cnt, 1);
         chk(load_done_bit == base, "R7", "bits sent before packet loaded",
             load_done_bit - base, 0);
      end else begin
         chk(irq_cnt == 0, "R7", "irq pulses in streaming mode", irq_cnt, 0);
      end
   endtask

   task automatic t_reset;
      chk(!busy_o && !irq_o && !bit_stb_o && !byte_req_o, "R1", "outputs in reset",
          {busy_o, irq_o, bit_stb_o, byte_req_o}, 0);
   endtask

   task automatic t_stream_node;   run_frame(1, 0, 0, 0, 5, 0, 0, "R2");  endtask
   task automatic t_stream_global; run_frame(1, 1, 0, 0, 3, 0, 0, "R3");  endtask
   task automatic t_no_id;         run_frame(0, 0, 0, 0, 4, 0, 0, "R4");  endtask
   task automatic t_slow_host;     run_frame(1, 0, 0, 0, 6, 1, 0, "R5");  endtask
   task automatic t_crc_stream;    run_frame(1, 0, 0, 1, 9, 1, 0, "R8");  endtask
   task automatic t_buffered;      run_frame(1, 1, 1, 1, 12, 0, 0, "R7"); endtask
   task automatic t_buffered_nocrc; run_frame(0, 0, 1, 0, 7, 1, 0, "R8"); endtask
   task automatic t_zero_len;
      run_frame(1, 0, 0, 1, 0, 0, 0, "R9");
      run_frame(1, 1, 1, 1, 0, 1, 0, "R9");
   endtask
   task automatic t_busy_start;    run_frame(1, 0, 0, 1, 4, 0, 60, "R11"); endtask

   initial begin
      #(8 * 150000);
      errors++;
      checks++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_stream_node();
      t_stream_global();
      t_no_id();
      t_slow_host();
      t_crc_stream();
      t_buffered();
      t_buffered_nocrc();
      t_zero_len();
      t_busy_start();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule